// File: doc/BRIEF.md
# Micro-op Cache Tag Store with Micro-op-Counted Capacity

This block keeps the bookkeeping side of a decoded micro-op cache: for each cached instruction address it holds the tag, the number of micro-ops that instruction decodes into, and a last-use stamp. Its capacity is a budget of micro-ops, not a number of entries. The front end presents the address of each fetched micro-op on the lookup port. A hit tells fetch that it can skip the instruction cache. The hit also makes that entry the most recently used. Every lookup, whether it hits or misses, is counted, and every hit is counted separately.

When an instruction-cache fill completes, fetch sends the instruction address and its micro-op count on the fill port, which is a valid/ready stream. The block handles each accepted fill as a short sequence. First it removes whole least-recently-used instructions, one per cycle, until the new instruction's micro-ops fit in the budget and a tag slot is free. Then it inserts the new entry. `fill_ready` stays low for that whole sequence, which is the only back-pressure on the fill port. A fill is transferred on a rising edge where `fill_valid` and `fill_ready` are both high. The sender must hold address and count stable while valid is high and ready is low. Fills that are dropped or ignored are taken in one cycle and leave `fill_ready` high.

Recency comes from a free-running cycle counter. The tags sit in a fully associative array. The victim is the valid entry with the smallest stamp, and on a tie the lowest slot index wins.

Top module: `uop_cache`

## Requirements
- R1: `lk_hit` is high in the same cycle as `lk_valid` exactly when `lk_addr` matches a resident entry, and is low whenever `lk_valid` is low.
- R2: `stat_lookups` increments by one on every edge where `lk_valid` is high, and `stat_hits` increments by one on every edge where `lk_hit` is high. Both wrap modulo 2^SW, and `stat_hits` never exceeds `stat_lookups` before a wrap.
- R3: A lookup hit makes its entry the most recently used, so later evictions take every other resident entry first.
- R4: `occupancy` always equals the sum of the micro-op counts of the resident entries, and never exceeds CAP_UOPS.
- R5: A fill whose address is already resident is ignored: no eviction, no change to occupancy or recency.
- R6: A fill whose count is 0 or greater than CAP_UOPS is dropped without evicting anything.
- R7: An accepted fill evicts least-recently-used whole entries, one per cycle, until occupancy plus the new count is at most CAP_UOPS. It then inserts the entry as the most recently used and adds its count to occupancy.
- R8: `fill_ready` is high whenever no fill is being processed. It goes low on the edge after a fill that will be inserted, and stays low until the insertion edge. Dropped and ignored fills keep it high. Occupancy never changes on an edge where `fill_ready` was high.
- R9: When all SLOTS tag slots are in use, an accepted fill evicts the least-recently-used entry even if its micro-ops would fit in the budget.
- R10: After reset the cache is empty: occupancy 0, both counters 0, no hits, `fill_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_addr | input | AW | Instruction address to look up |
| lk_hit | output | 1 | Address is resident (combinational) |
| fill_valid | input | 1 | Fill request valid |
| fill_ready | output | 1 | Fill port can accept |
| fill_addr | input | AW | Address of the filled instruction |
| fill_count | input | CW | Micro-ops of the filled instruction |
| occupancy | output | clog2(CAP_UOPS+1) | Micro-ops currently held |
| stat_lookups | output | SW | Lookup counter |
| stat_hits | output | SW | Hit counter |

## Verification
A small configuration with 4 slots and an 8-micro-op budget is driven first by a directed sequence and then by a long pseudo-random sweep over 8 addresses and counts 0 to 10. The directed part separates four cases: an eviction forced by the budget, an eviction forced by running out of slots, a repeat fill of a resident address, and fills dropped because their count is zero or too large. It also checks that a lookup hit reorders the victims. The sweep is compared against a behavioural model, and the hit result, occupancy and ready behaviour are checked after every operation. Because the counts are random, the sweep mixes budget evictions, evictions of several entries for one fill, and slot-limit evictions far more often than the directed cases do.

// File: rtl/uop_cache_pkg.sv
package uop_cache_pkg;
  typedef enum logic {
    FS_IDLE = 1'b0,
    FS_BUSY = 1'b1
  } fill_state_e;
endpackage

// File: rtl/uc_tag_match.sv
module uc_tag_match #(
  parameter int SLOTS = 64,
  parameter int AW    = 32
) (
  input  logic [SLOTS-1:0]         valid_vec,
  input  logic [SLOTS-1:0][AW-1:0] tags,
  input  logic [AW-1:0]            key,
  output logic [SLOTS-1:0]         match_vec
);
  for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
    assign match_vec[g] = valid_vec[g] && (tags[g] == key);
  end
endmodule

// File: rtl/uc_victim_pick.sv
module uc_victim_pick #(
  parameter int SLOTS = 64,
  parameter int TS_W  = 32,
  localparam int IW   = $clog2(SLOTS)
) (
  input  logic [SLOTS-1:0]           valid_vec,
  input  logic [SLOTS-1:0][TS_W-1:0] stamps,
  output logic [IW-1:0]              victim_idx,
  output logic [IW-1:0]              free_idx,
  output logic                       free_found
);
  logic            have_best;
  logic [TS_W-1:0] best_ts;

  // Oldest valid stamp; strict compare keeps the lowest index on a tie.
  always_comb begin
    have_best  = 1'b0;
    best_ts    = '0;
    victim_idx = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (valid_vec[i] && (!have_best || stamps[i] < best_ts)) begin
        have_best  = 1'b1;
        best_ts    = stamps[i];
        victim_idx = IW'(i);
      end
    end
  end

  // Lowest-index empty slot.
  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (!valid_vec[i] && !free_found) begin
        free_found = 1'b1;
        free_idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/uop_cache.sv
module uop_cache
  import uop_cache_pkg::*;
#(
  parameter int AW       = 32,
  parameter int SLOTS    = 64,
  parameter int CAP_UOPS = 2304,
  parameter int CW       = 6,
  parameter int TS_W     = 32,
  parameter int SW       = 32,
  localparam int OW      = $clog2(CAP_UOPS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lk_valid,
  input  logic [AW-1:0] lk_addr,
  output logic          lk_hit,
  input  logic          fill_valid,
  output logic          fill_ready,
  input  logic [AW-1:0] fill_addr,
  input  logic [CW-1:0] fill_count,
  output logic [OW-1:0] occupancy,
  output logic [SW-1:0] stat_lookups,
  output logic [SW-1:0] stat_hits
);
  localparam int IW   = $clog2(SLOTS);
  localparam int SUMW = ((OW > CW) ? OW : CW) + 1;
  localparam logic [SUMW-1:0] CAP_X = SUMW'(CAP_UOPS);

  logic [SLOTS-1:0]           slot_v;
  logic [SLOTS-1:0][AW-1:0]   slot_tag;
  logic [SLOTS-1:0][CW-1:0]   slot_cnt;
  logic [SLOTS-1:0][TS_W-1:0] slot_ts;
  logic [TS_W-1:0]            ts_now;

  fill_state_e   fstate;
  logic [AW-1:0] pend_addr;
  logic [CW-1:0] pend_cnt;

  logic [SLOTS-1:0] lk_match, fill_match;
  logic [IW-1:0]    lk_idx, victim_idx, free_idx;
  logic             free_found, lk_any;
  logic             fill_take, fill_drop, need_room;

  uc_tag_match #(.SLOTS(SLOTS), .AW(AW)) u_lk_match (
    .valid_vec(slot_v), .tags(slot_tag), .key(lk_addr), .match_vec(lk_match)
  );

  uc_tag_match #(.SLOTS(SLOTS), .AW(AW)) u_fill_match (
    .valid_vec(slot_v), .tags(slot_tag), .key(fill_addr), .match_vec(fill_match)
  );

  uc_victim_pick #(.SLOTS(SLOTS), .TS_W(TS_W)) u_pick (
    .valid_vec(slot_v), .stamps(slot_ts), .victim_idx(victim_idx),
    .free_idx(free_idx), .free_found(free_found)
  );

  always_comb begin
    lk_idx = '0;
    lk_any = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      if (lk_match[i]) begin
        lk_idx = IW'(i);
        lk_any = 1'b1;
      end
    end
  end

  assign lk_hit     = lk_valid && lk_any;
  assign fill_ready = (fstate == FS_IDLE);
  assign fill_take  = fill_valid && fill_ready;
  assign fill_drop  = (|fill_match) || (fill_count == '0) ||
                      (SUMW'(fill_count) > CAP_X);
  assign need_room  = ((SUMW'(occupancy) + SUMW'(pend_cnt)) > CAP_X) || !free_found;

  // Statistics and the recency clock.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ts_now       <= '0;
      stat_lookups <= '0;
      stat_hits    <= '0;
    end else begin
      ts_now <= ts_now + TS_W'(1);
      if (lk_valid) stat_lookups <= stat_lookups + SW'(1);
      if (lk_hit)   stat_hits    <= stat_hits + SW'(1);
    end
  end

  // Fill sequencing: capture, evict one entry per cycle, then insert.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fstate    <= FS_IDLE;
      pend_addr <= '0;
      pend_cnt  <= '0;
      occupancy <= '0;
      slot_v    <= '0;
      slot_tag  <= '0;
      slot_cnt  <= '0;
      slot_ts   <= '0;
    end else begin
      if (lk_hit) slot_ts[lk_idx] <= ts_now;
      case (fstate)
        FS_IDLE: begin
          if (fill_take && !fill_drop) begin
            fstate    <= FS_BUSY;
            pend_addr <= fill_addr;
            pend_cnt  <= fill_count;
          end
        end
        FS_BUSY: begin
          if (need_room) begin
            slot_v[victim_idx] <= 1'b0;
            occupancy <= occupancy - OW'(slot_cnt[victim_idx]);
          end else begin
            slot_v[free_idx]   <= 1'b1;
            slot_tag[free_idx] <= pend_addr;
            slot_cnt[free_idx] <= pend_cnt;
            slot_ts[free_idx]  <= ts_now;
            occupancy <= occupancy + OW'(pend_cnt);
            fstate    <= FS_IDLE;
          end
        end
        default: fstate <= FS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uop_cache_chk.sv
module uop_cache_chk #(
  parameter int CAP_UOPS = 2304,
  parameter int SW       = 32,
  localparam int OW      = $clog2(CAP_UOPS + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lk_valid,
  input logic          lk_hit,
  input logic          fill_valid,
  input logic          fill_ready,
  input logic [OW-1:0] occupancy,
  input logic [SW-1:0] stat_lookups,
  input logic [SW-1:0] stat_hits
);
  AST_HIT_NEEDS_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_valid); // R1

  AST_LOOKUP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> stat_lookups == $past(stat_lookups) + SW'(1)); // R2

  AST_LOOKUP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> $stable(stat_lookups)); // R2

  AST_HIT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |=> stat_hits == $past(stat_hits) + SW'(1)); // R2

  AST_MISS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |=> $stable(stat_hits)); // R2

  AST_OCC_WITHIN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= OW'(CAP_UOPS)); // R4

  AST_OCC_FROZEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    fill_ready |=> occupancy == $past(occupancy)); // R8

  AST_READY_DROP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_ready && !fill_valid) |=> fill_ready); // R8
endmodule

bind uop_cache uop_cache_chk #(.CAP_UOPS(CAP_UOPS), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_hit(lk_hit),
  .fill_valid(fill_valid), .fill_ready(fill_ready), .occupancy(occupancy),
  .stat_lookups(stat_lookups), .stat_hits(stat_hits)
);

// File: tb/tb_uop_cache.sv
module tb_uop_cache;
  localparam int AW = 8, SLOTS = 4, CAP = 8, CW = 4, TS_W = 16, SW = 16;
  localparam int OW = $clog2(CAP + 1);
  localparam int NADDR = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_valid = 1'b0, fill_valid = 1'b0;
  logic [AW-1:0] lk_addr = '0, fill_addr = '0;
  logic [CW-1:0] fill_count = '0;
  logic lk_hit, fill_ready;
  logic [OW-1:0] occupancy;
  logic [SW-1:0] stat_lookups, stat_hits;

  int n_checks = 0, n_errors = 0;

  // Behavioural model, indexed by address.
  bit m_res[NADDR];
  int m_cnt[NADDR];
  int m_age[NADDR];
  int m_occ = 0, m_seq = 0, m_look = 0, m_hits = 0;

  always #5 clk = ~clk;

  uop_cache #(.AW(AW), .SLOTS(SLOTS), .CAP_UOPS(CAP), .CW(CW), .TS_W(TS_W), .SW(SW)) dut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_hit(lk_hit),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_addr(fill_addr),
    .fill_count(fill_count), .occupancy(occupancy), .stat_lookups(stat_lookups),
    .stat_hits(stat_hits)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit model_fill(input int a, input int c);
    int nres, v;
    if (c == 0 || c > CAP || m_res[a]) return 1'b0;
    forever begin
      nres = 0;
      v = -1;
      for (int i = 0; i < NADDR; i++) begin
        if (m_res[i]) begin
          nres++;
          if (v < 0 || m_age[i] < m_age[v]) v = i;
        end
      end
      if (m_occ + c > CAP || nres == SLOTS) begin
        m_res[v] = 1'b0;
        m_occ -= m_cnt[v];
      end else break;
    end
    m_res[a] = 1'b1;
    m_cnt[a] = c;
    m_age[a] = m_seq++;
    m_occ += c;
    return 1'b1;
  endfunction

  task automatic do_lookup(input int a, input string req);
    @(negedge clk);
    lk_valid = 1'b1;
    lk_addr  = AW'(a);
    #1;
    chk(lk_hit == m_res[a], req, int'(lk_hit), int'(m_res[a]));
    m_look++;
    if (m_res[a]) begin
      m_hits++;
      m_age[a] = m_seq++;
    end
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic do_fill(input int a, input int c, input string req);
    bit ins;
    @(negedge clk);
    chk(fill_ready == 1'b1, "R8", int'(fill_ready), 1);
    fill_valid = 1'b1;
    fill_addr  = AW'(a);
    fill_count = CW'(c);
    @(posedge clk);
    ins = model_fill(a, c);
    @(negedge clk);
    fill_valid = 1'b0;
    chk(fill_ready == !ins, "R8", int'(fill_ready), int'(!ins));
    for (int k = 0; k < 64 && !fill_ready; k++) @(negedge clk);
    chk(occupancy == OW'(m_occ), req, int'(occupancy), m_occ);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R10: reset state
    chk(occupancy == '0, "R10", int'(occupancy), 0);
    chk(stat_lookups == '0 && stat_hits == '0, "R10", int'(stat_lookups), 0);
    chk(fill_ready == 1'b1, "R10", int'(fill_ready), 1);
    do_lookup(1, "R10");

    do_fill(1, 3, "R7");               // occupancy 3
    do_lookup(1, "R1");
    do_fill(1, 2, "R5");               // resident: ignored
    chk(occupancy == 3, "R5", int'(occupancy), 3);
    do_fill(2, 4, "R7");               // occupancy 7
    do_lookup(1, "R3");                // 1 becomes newest
    do_fill(3, 2, "R7");               // 9 > 8: evict 2
    chk(occupancy == 5, "R7", int'(occupancy), 5);
    do_lookup(2, "R3");                // miss: 2 was victim
    do_lookup(1, "R3");                // hit: refresh kept it
    do_fill(4, 9, "R6");               // over capacity: dropped
    do_fill(5, 0, "R6");               // zero count: dropped
    chk(occupancy == 5, "R6", int'(occupancy), 5);
    do_lookup(1, "R6");
    do_fill(6, 1, "R7");               // 6
    do_fill(7, 1, "R7");               // 7, all four slots used
    do_fill(0, 1, "R9");               // fits, but slot limit evicts 3
    chk(occupancy == 6, "R9", int'(occupancy), 6);
    do_lookup(3, "R9");
    do_lookup(0, "R9");

    // Pseudo-random sweep against the model.
    lfsr = 16'hACE1;
    for (int n = 0; n < 1500; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[0]) do_lookup(int'(lfsr[3:1]), "R1");
      else do_fill(int'(lfsr[3:1]), int'(lfsr[15:8]) % 11, "R4");
    end

    @(negedge clk);
    chk(stat_lookups == SW'(m_look), "R2", int'(stat_lookups), m_look);
    chk(stat_hits == SW'(m_hits), "R2", int'(stat_hits), m_hits);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule